// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight hardware interrupt request lines and presents them to a processor through one interrupt output. Each request is latched into a pending register and held there until the processor accepts it. A programmable mask filters the pending requests. A fixed-priority resolver then picks the lowest-numbered pending, unmasked line, provided no line of equal or higher priority is already being serviced.

The processor accepts an interrupt with two acknowledge pulses. The first pulse freezes the winning line, moves it from pending to in-service, and drops the interrupt output. The second pulse produces an 8-bit vector for one cycle. The vector is a programmable 5-bit base followed by the 3-bit line index. Software clears in-service state with an end-of-interrupt command, written through a small register-write port. The same port also loads the mask and the vector base.

Top module: `vpic_top`

## Requirements
- R1: After reset, every mask bit is set, no request is pending or in service, `irq_o` is low and `vec_vld_o` is low.
- R2: A request on a masked line does not raise `irq_o`. Clearing that mask bit later raises `irq_o` from the cycle after the write.
- R3: A request seen high on any clock edge stays pending after the input drops, until a first acknowledge pulse takes it.
- R4: Among eligible pending lines, the lowest index wins, so line 0 has the highest priority.
- R5: A pending line raises `irq_o` only when no line with an equal or lower index is in service.
- R6: A first acknowledge pulse while `irq_o` is high drops `irq_o` from the next cycle. It also moves the winning line from pending to in-service.
- R7: The second acknowledge pulse makes `vec_vld_o` high for exactly one cycle, the cycle after that edge. In that cycle `vec_o` = {base[4:0], line index[2:0]}.
- R8: A write with `wr_sel_i` = 2 (non-specific end of interrupt) clears the lowest-index in-service bit. `wr_data_i` is ignored for this command.
- R9: A write with `wr_sel_i` = 3 (specific end of interrupt) clears the in-service bit selected by `wr_data_i[2:0]`.
- R10: A write with `wr_sel_i` = 0 loads the mask from `wr_data_i`, where bit k masks line k. A write with `wr_sel_i` = 1 loads the base from `wr_data_i[7:3]`. Both take effect on the next cycle.
- R11: After the second acknowledge, `irq_o` rises again only if another eligible request exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Interrupt request lines, bit k is line k |
| ack_i | input | 1 | Acknowledge pulse from the processor |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 mask, 1 base, 2 non-specific EOI, 3 specific EOI |
| wr_data_i | input | 8 | Write data |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Interrupt vector |
| vec_vld_o | output | 1 | Vector valid, one cycle |

## Verification
Latching a request, writing a register and taking the first acknowledge each change state on the clock edge where they are sampled. `irq_o` is decoded from that state, so it reflects the change in the cycle that follows the edge. The vector is a registered output and is valid only in the cycle after the second acknowledge edge. It is low again one edge later. The bench applies each stimulus for exactly one edge and samples shortly after that edge. It then checks the valid pulse again one edge later, so each result is read in the single cycle in which it is due.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    parameter int N_LINES = 8;
    parameter int VEC_W   = 8;
    parameter int IDX_W   = $clog2(N_LINES);
    parameter int BASE_W  = VEC_W - IDX_W;

    parameter logic [1:0] SEL_MASK   = 2'd0;
    parameter logic [1:0] SEL_BASE   = 2'd1;
    parameter logic [1:0] SEL_EOI_NS = 2'd2;
    parameter logic [1:0] SEL_EOI_SP = 2'd3;

    typedef enum logic {PH_IDLE = 1'b0, PH_FROZEN = 1'b1} phase_e;

    typedef struct packed {
        logic [N_LINES-1:0] imr;
        logic [N_LINES-1:0] irr;
        logic [N_LINES-1:0] isr;
        logic [BASE_W-1:0]  base;
        phase_e             ph;
        logic [IDX_W-1:0]   sel_idx;
        logic [VEC_W-1:0]   vec;
        logic               vld;
    } state_t;
endpackage

// File: rtl/vpic_ffs.sv
module vpic_ffs #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (bits_i[k]) begin
                found_o = 1'b1;
                idx_o   = IW'(k);
            end
        end
    end
endmodule

// File: rtl/vpic_gate.sv
module vpic_gate #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  isr_i,
    input  logic [IW-1:0] cand_i,
    output logic          blocked_o
);
    logic [N-1:0] at_or_above;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign at_or_above[g] = isr_i[g] && (IW'(g) <= cand_i);
        end
    endgenerate

    assign blocked_o = |at_or_above;
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_LINES-1:0]  req_i,
    input  logic                ack_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_sel_i,
    input  logic [VEC_W-1:0]    wr_data_i,
    output logic                irq_o,
    output logic [VEC_W-1:0]    vec_o,
    output logic                vec_vld_o
);
    state_t q, d;

    logic [N_LINES-1:0] pend;
    logic               win_found;
    logic [IDX_W-1:0]   win_idx;
    logic               win_blocked;
    logic               eligible;
    logic               isr_found;
    logic [IDX_W-1:0]   isr_top;

    assign pend = q.irr & ~q.imr;

    vpic_ffs #(.N(N_LINES), .IW(IDX_W)) u_win (
        .bits_i (pend),
        .found_o(win_found),
        .idx_o  (win_idx)
    );

    vpic_gate #(.N(N_LINES), .IW(IDX_W)) u_gate (
        .isr_i    (q.isr),
        .cand_i   (win_idx),
        .blocked_o(win_blocked)
    );

    vpic_ffs #(.N(N_LINES), .IW(IDX_W)) u_isr (
        .bits_i (q.isr),
        .found_o(isr_found),
        .idx_o  (isr_top)
    );

    assign eligible = win_found && !win_blocked;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.irr = q.irr | req_i;

        if (wr_en_i) begin
            unique case (wr_sel_i)
                SEL_MASK:   d.imr = wr_data_i;
                SEL_BASE:   d.base = wr_data_i[VEC_W-1:IDX_W];
                SEL_EOI_NS: if (isr_found) d.isr[isr_top] = 1'b0;
                SEL_EOI_SP: d.isr[wr_data_i[IDX_W-1:0]] = 1'b0;
                default:    d.imr = q.imr;
            endcase
        end

        if (ack_i) begin
            if (q.ph == PH_IDLE) begin
                d.ph = PH_FROZEN;
                if (eligible) begin
                    d.isr[win_idx] = 1'b1;
                    d.irr[win_idx] = 1'b0;
                    d.sel_idx      = win_idx;
                end else begin
                    d.sel_idx = '1;
                end
            end else begin
                d.ph  = PH_IDLE;
                d.vec = {q.base, q.sel_idx};
                d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.imr     <= '1;
            q.irr     <= '0;
            q.isr     <= '0;
            q.base    <= '0;
            q.ph      <= PH_IDLE;
            q.sel_idx <= '0;
            q.vec     <= '0;
            q.vld     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign irq_o     = (q.ph == PH_IDLE) && eligible;
    assign vec_o     = q.vec;
    assign vec_vld_o = q.vld;

    p_masked_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((q.irr & ~q.imr) != '0));

    p_frozen_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_FROZEN) |-> !irq_o);

    p_ack_to_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !(wr_en_i && wr_sel_i[1]))
        |=> ($countones(q.isr) == $past($countones(q.isr)) + 1));

    p_vec_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |=> !vec_vld_o);

    p_eoi_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_EOI_NS && q.isr != '0 && !ack_i)
        |=> ($countones(q.isr) == $past($countones(q.isr)) - 1));
endmodule

// File: tb/tb_vpic_top.sv
`timescale 1ns/1ps
module tb_vpic_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_i;
    logic       ack_i;
    logic       wr_en_i;
    logic [1:0] wr_sel_i;
    logic [7:0] wr_data_i;
    logic       irq_o;
    logic [7:0] vec_o;
    logic       vec_vld_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vpic_top dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .irq_o(irq_o), .vec_o(vec_o), .vec_vld_o(vec_vld_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] data);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic raise(logic [7:0] lines);
        req_i = lines;
        tick();
        req_i = '0;
    endtask

    task automatic ack_first();
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0;
        chk("R6 irq low after first ack", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic ack_second(logic [4:0] base, int line);
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0;
        chk("R7 vector valid", {31'd0, vec_vld_o}, 32'd1);
        chk("R7 vector value", {24'd0, vec_o}, {24'd0, base, 3'(line)});
        tick();
        chk("R7 valid one cycle", {31'd0, vec_vld_o}, 32'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_i = '0; ack_i = 1'b0;
        wr_en_i = 1'b0; wr_sel_i = '0; wr_data_i = '0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
        chk("R1 vld after reset", {31'd0, vec_vld_o}, 32'd0);

        // R1, R2: everything masked at reset
        raise(8'h10);
        chk("R2 masked line stays quiet", {31'd0, irq_o}, 32'd0);
        tick(); tick();
        chk("R3 still no irq while masked", {31'd0, irq_o}, 32'd0);
        wr(2'd0, 8'hEF);
        chk("R2 R10 unmask raises irq from held request", {31'd0, irq_o}, 32'd1);
        wr(2'd1, 8'hA8);
        ack_first();
        ack_second(5'h15, 4);
        chk("R11 no further request", {31'd0, irq_o}, 32'd0);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h00);
        chk("R8 nothing pending after eoi", {31'd0, irq_o}, 32'd0);

        // R4 R5 R8 R9: every pair of lines
        for (int a = 0; a < 8; a++) begin
            for (int b = a + 1; b < 8; b++) begin
                logic [4:0] base;
                base = 5'((a * 8 + b) & 31);
                wr(2'd1, {base, 3'b000});
                raise(8'(1 << a) | 8'(1 << b));
                chk("R4 pair raises irq", {31'd0, irq_o}, 32'd1);
                ack_first();
                ack_second(base, a);
                chk("R5 lower line blocked by service", {31'd0, irq_o}, 32'd0);
                wr(2'd2, 8'hFF);
                chk("R8 R11 eoi frees pending line", {31'd0, irq_o}, 32'd1);
                ack_first();
                ack_second(base, b);
                wr(2'd3, 8'(b));
                chk("R9 specific eoi leaves idle", {31'd0, irq_o}, 32'd0);
                raise(8'(1 << b));
                chk("R9 line serviceable again", {31'd0, irq_o}, 32'd1);
                ack_first();
                ack_second(base, b);
                wr(2'd3, 8'(b));
            end
        end

        // R5 nesting: a higher line interrupts a lower one in service
        wr(2'd1, 8'h38);
        raise(8'h20);
        ack_first();
        ack_second(5'h07, 5);
        raise(8'h04);
        chk("R5 higher line nests", {31'd0, irq_o}, 32'd1);
        ack_first();
        ack_second(5'h07, 2);
        raise(8'h80);
        chk("R5 lower line blocked while nested", {31'd0, irq_o}, 32'd0);
        wr(2'd2, 8'h00);
        chk("R8 clears highest only", {31'd0, irq_o}, 32'd0);
        wr(2'd2, 8'h00);
        chk("R8 second eoi releases line 7", {31'd0, irq_o}, 32'd1);
        ack_first();
        ack_second(5'h07, 7);
        wr(2'd2, 8'h00);

        // R10: masking a pending line after latch
        raise(8'h02);
        wr(2'd0, 8'h02);
        chk("R10 mask write hides pending", {31'd0, irq_o}, 32'd0);
        wr(2'd0, 8'h00);
        chk("R10 unmask write shows pending", {31'd0, irq_o}, 32'd1);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule